// File: doc/BRIEF.md
# GPIO Pin Event Interrupt Detector

This block watches a vector of already synchronised GPIO input pins and turns selected pin events into per-pin interrupt requests. Each pin can independently respond to any mix of four event kinds. These are a low-to-high transition, a high-to-low transition, the pin sitting high, and the pin sitting low. Software picks the mix through four enable vectors, one per event kind.

Every detected event sets a bit in a sticky status vector. Software clears a bit by writing a one to its position; writing a zero leaves the bit alone. An interrupt-enable vector decides which status bits reach the interrupt outputs. A test strobe lets software set status bits directly, so that the interrupt path can be exercised without moving any pin.

The block is driven by already-decoded register write strobes that share one write data bus. It returns the status vector and the sampled pin values for readback.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous reset, the status vector, all enable vectors, the interrupt outputs and the pin sample readback are all zero.
- R2: A pin whose rise-enable bit is set marks its status bit at the clock edge where its previous sample is 0 and its present value is 1. The bit is visible on `status_o` from the following cycle.
- R3: A pin whose fall-enable bit is set marks its status bit at the clock edge where its previous sample is 1 and its present value is 0.
- R4: A pin whose high-enable bit is set marks its status bit on every cycle it is high. A clear written while the pin stays high is therefore undone at once.
- R5: A pin whose low-enable bit is set marks its status bit on every cycle it is low.
- R6: Pin activity on a pin with none of its four event-enable bits set has no effect on that pin's status bit.
- R7: When `stat_clr_we` is asserted, each `wdata` bit at 1 clears the status bit at the same position. Bits at 0 leave their status bit unchanged. Status bits otherwise hold their value.
- R8: If a set from a detected event or the test strobe meets a clear of the same bit in the same cycle, the bit ends up set.
- R9: Each `irq_o` bit equals the matching status bit ANDed with the matching interrupt-enable bit. Enable bits are loaded from `wdata` when `ien_we` is asserted.
- R10: When `test_we` is asserted, each `wdata` bit at 1 sets the matching status bit, and no pin activity is needed.
- R11: `din_o` returns the pin vector sampled at the previous clock edge.
- R12: Each enable vector (rise, fall, high, low, interrupt enable) changes only in the cycle after its own write strobe, and then takes the value of `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_PIN | Synchronised pin levels |
| wdata | input | N_PIN | Write data shared by all strobes |
| rise_we | input | 1 | Load rise-enable vector |
| fall_we | input | 1 | Load fall-enable vector |
| high_we | input | 1 | Load high-level-enable vector |
| low_we | input | 1 | Load low-level-enable vector |
| ien_we | input | 1 | Load interrupt-enable vector |
| stat_clr_we | input | 1 | Write-one-to-clear the status vector |
| test_we | input | 1 | Write-one-to-set the status vector |
| irq_o | output | N_PIN | Per-pin interrupt requests |
| status_o | output | N_PIN | Sticky status readback |
| din_o | output | N_PIN | Sampled pin readback |

## Verification
A hardware set and a software clear of the same status bit can fall in the same cycle. The set may come from a level event, an edge event or the test strobe. This collision is forced in two ways. Directed steps write a clear while a high-enabled pin stays high, and assert `test_we` and `stat_clr_we` together with overlapping data. Random stimulus then mixes clear and test strobes with pin toggles. The outcome is judged against a bench model in which a set always overrides a clear, and the result is compared bit by bit on `status_o` and `irq_o` one cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned PIN_W_DEF = 32;

    // Per-pin selection of the event kinds that count
    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic low;
    } det_sel_t;

    // Previous and present sample of one pin
    typedef struct packed {
        logic prev;
        logic cur;
    } pin_smp_t;

    function automatic logic det_hit(det_sel_t s, pin_smp_t p);
        logic e_rise;
        logic e_fall;
        e_rise = ~p.prev & p.cur;
        e_fall = p.prev & ~p.cur;
        return (s.rise & e_rise) | (s.fall & e_fall) |
               (s.high & p.cur)  | (s.low & ~p.cur);
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PIN = PIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] wdata,
    input  logic             rise_we,
    input  logic             fall_we,
    input  logic             high_we,
    input  logic             low_we,
    input  logic             ien_we,
    output det_sel_t         sel [N_PIN],
    output logic [N_PIN-1:0] ien_q
);

    logic [N_PIN-1:0] rise_q, fall_q, high_q, low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
            high_q <= '0;
            low_q  <= '0;
            ien_q  <= '0;
        end else begin
            if (rise_we) rise_q <= wdata;
            if (fall_we) fall_q <= wdata;
            if (high_we) high_q <= wdata;
            if (low_we)  low_q  <= wdata;
            if (ien_we)  ien_q  <= wdata;
        end
    end

    for (genvar i = 0; i < N_PIN; i++) begin : g_sel
        assign sel[i] = '{rise: rise_q[i], fall: fall_q[i],
                          high: high_q[i], low: low_q[i]};
    end

    // R12: configuration only moves on its own strobe
    a_r12_rise_hold: assert property (@(posedge clk) disable iff (rst)
        !rise_we |=> $stable(rise_q));
    a_r12_fall_hold: assert property (@(posedge clk) disable iff (rst)
        !fall_we |=> $stable(fall_q));
    a_r12_high_hold: assert property (@(posedge clk) disable iff (rst)
        !high_we |=> $stable(high_q));
    a_r12_low_hold: assert property (@(posedge clk) disable iff (rst)
        !low_we |=> $stable(low_q));
    a_r12_ien_hold: assert property (@(posedge clk) disable iff (rst)
        !ien_we |=> $stable(ien_q));

endmodule

// File: rtl/gpio_irq_evt.sv
module gpio_irq_evt
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PIN = PIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] pin_i,
    input  det_sel_t         sel [N_PIN],
    output logic [N_PIN-1:0] prev_q,
    output logic [N_PIN-1:0] hit
);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_i;
    end

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        pin_smp_t smp;
        assign smp    = '{prev: prev_q[i], cur: pin_i[i]};
        assign hit[i] = det_hit(sel[i], smp);

        // R2/R3: with no level kind enabled, an event needs a pin change
        a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && !sel[i].high && !sel[i].low) |-> (pin_i[i] != prev_q[i]));
        // R6: a pin with nothing enabled raises no event
        a_r6_quiet_pin: assert property (@(posedge clk) disable iff (rst)
            (sel[i] == '0) |-> !hit[i]);
    end

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PIN = PIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] set_vec,
    input  logic [N_PIN-1:0] clr_vec,
    output logic [N_PIN-1:0] status_q
);

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // R7: bits not cleared never drop
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));
    // R7: cleared bits with no set go low
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(clr_vec) & ~$past(set_vec)) == '0));
    // R8: a set always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_vec) & ~status_q) == '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PIN = PIN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_PIN-1:0] pin_i,
    input  logic [N_PIN-1:0] wdata,
    input  logic             rise_we,
    input  logic             fall_we,
    input  logic             high_we,
    input  logic             low_we,
    input  logic             ien_we,
    input  logic             stat_clr_we,
    input  logic             test_we,
    output logic [N_PIN-1:0] irq_o,
    output logic [N_PIN-1:0] status_o,
    output logic [N_PIN-1:0] din_o
);

    det_sel_t         sel [N_PIN];
    logic [N_PIN-1:0] ien_q;
    logic [N_PIN-1:0] prev_q;
    logic [N_PIN-1:0] hit;
    logic [N_PIN-1:0] set_vec;
    logic [N_PIN-1:0] clr_vec;

    gpio_irq_cfg #(.N_PIN(N_PIN)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wdata   (wdata),
        .rise_we (rise_we),
        .fall_we (fall_we),
        .high_we (high_we),
        .low_we  (low_we),
        .ien_we  (ien_we),
        .sel     (sel),
        .ien_q   (ien_q)
    );

    gpio_irq_evt #(.N_PIN(N_PIN)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .sel    (sel),
        .prev_q (prev_q),
        .hit    (hit)
    );

    assign set_vec = hit | (test_we ? wdata : '0);
    assign clr_vec = stat_clr_we ? wdata : '0;

    gpio_irq_stat #(.N_PIN(N_PIN)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .status_q (status_o)
    );

    assign irq_o = status_o & ien_q;
    assign din_o = prev_q;

    // R9: no request without a pending status bit
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~status_o) == '0);
    // R10: a test write shows up in status next cycle
    a_r10_test_sets: assert property (@(posedge clk) disable iff (rst)
        test_we |=> ((status_o & $past(wdata)) == $past(wdata)));
    // R11: readback follows the pins by one cycle
    a_r11_din_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (din_o == $past(pin_i)));

endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;

    localparam int N = 32;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] pin_i, wdata;
    logic         rise_we, fall_we, high_we, low_we, ien_we, stat_clr_we, test_we;
    logic [N-1:0] irq_o, status_o, din_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [N-1:0] m_prev, m_stat, m_rise, m_fall, m_high, m_low, m_ien;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_detect #(.N_PIN(N)) dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wdata(wdata),
        .rise_we(rise_we), .fall_we(fall_we), .high_we(high_we),
        .low_we(low_we), .ien_we(ien_we), .stat_clr_we(stat_clr_we),
        .test_we(test_we), .irq_o(irq_o), .status_o(status_o), .din_o(din_o)
    );

    function automatic logic [N-1:0] ref_status(
        logic [N-1:0] st, logic [N-1:0] pv, logic [N-1:0] pn,
        logic [N-1:0] r, logic [N-1:0] f, logic [N-1:0] h, logic [N-1:0] l,
        logic [N-1:0] wd, logic clr, logic tst);
        logic [N-1:0] ev;
        ev = (r & ~pv & pn) | (f & pv & ~pn) | (h & pn) | (l & ~pn);
        if (tst) ev = ev | wd;
        return (st & ~(clr ? wd : '0)) | ev;
    endfunction

    task automatic chk(string tag, string what, logic [N-1:0] got, logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        wdata = '0; rise_we = 0; fall_we = 0; high_we = 0; low_we = 0;
        ien_we = 0; stat_clr_we = 0; test_we = 0;
    endtask

    // one clock: update model from present inputs, then compare outputs
    task automatic step(string tag);
        logic [N-1:0] nst;
        nst = ref_status(m_stat, m_prev, pin_i, m_rise, m_fall, m_high, m_low,
                         wdata, stat_clr_we, test_we);
        @(posedge clk);
        m_stat = nst;
        m_prev = pin_i;
        if (rise_we) m_rise = wdata;
        if (fall_we) m_fall = wdata;
        if (high_we) m_high = wdata;
        if (low_we)  m_low  = wdata;
        if (ien_we)  m_ien  = wdata;
        @(negedge clk);
        chk(tag, "status", status_o, m_stat);
        chk(tag, "irq", irq_o, m_stat & m_ien);
        chk(tag, "din", din_o, m_prev);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        idle_inputs();
        pin_i = '0;
        rst = 1;
        m_prev = '0; m_stat = '0; m_rise = '0; m_fall = '0;
        m_high = '0; m_low = '0; m_ien = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "status", status_o, '0);
        chk("R1", "irq", irq_o, '0);
        chk("R1", "din", din_o, '0);

        // R9: enable every interrupt output
        wdata = '1; ien_we = 1; step("R9");
        // R2: rising edges on pins 0 and 1
        wdata = 32'h0000_0003; rise_we = 1; step("R12");
        pin_i = 32'h0000_0003; step("R2");
        chk("R2", "bits0-1", status_o & 32'h3, 32'h3);
        // R7: clear bit 0 only, bit 1 stays
        wdata = 32'h1; stat_clr_we = 1; step("R7");
        chk("R7", "bits0-1", status_o & 32'h3, 32'h2);
        // R3: falling edge on pin 8
        wdata = 32'h0000_0100; fall_we = 1; step("R12");
        pin_i[8] = 1; step("R3");
        chk("R3", "bit8 after rise", status_o[8], 1'b0);
        pin_i[8] = 0; step("R3");
        chk("R3", "bit8 after fall", status_o[8], 1'b1);
        // R4: level high on pin 5, clear is undone at once
        wdata = 32'h0000_0020; high_we = 1; step("R12");
        pin_i[5] = 1; step("R4");
        wdata = 32'h0000_0020; stat_clr_we = 1; step("R4");
        chk("R4", "bit5 reasserted", status_o[5], 1'b1);
        pin_i[5] = 0; step("R4");
        wdata = 32'h0000_0020; stat_clr_we = 1; step("R4");
        chk("R4", "bit5 cleared", status_o[5], 1'b0);
        // R5: level low on pin 12 (pin already low)
        wdata = 32'h0000_1000; low_we = 1; step("R12");
        step("R5");
        chk("R5", "bit12", status_o[12], 1'b1);
        // R6: pin 20 toggles with nothing enabled
        for (int k = 0; k < 6; k++) begin
            pin_i[20] = ~pin_i[20]; step("R6");
            chk("R6", "bit20", status_o[20], 1'b0);
        end
        // R10 and R8: test set and clear of the same bits in one cycle
        wdata = 32'h00F0_0000; test_we = 1; step("R10");
        chk("R10", "bits20-23", status_o & 32'h00F0_0000, 32'h00F0_0000);
        wdata = 32'h00F0_0000; test_we = 1; stat_clr_we = 1; step("R8");
        chk("R8", "bits20-23", status_o & 32'h00F0_0000, 32'h00F0_0000);
        // R9: mask interrupts to upper half
        wdata = 32'hFFFF_0000; ien_we = 1; step("R9");
        chk("R9", "irq lower", irq_o & 32'h0000_FFFF, '0);
        // clean up before random
        wdata = '0; rise_we = 1; fall_we = 1; high_we = 1; low_we = 1; step("R12");
        wdata = '1; stat_clr_we = 1; step("R7");

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom % 16;
            pin_i = pin_i ^ ($urandom & $urandom & $urandom);
            wdata = $urandom;
            case (r)
                0: rise_we = 1;
                1: fall_we = 1;
                2: high_we = 1;
                3: low_we = 1;
                4: ien_we = 1;
                5, 6, 7: stat_clr_we = 1;
                8: test_we = 1;
                9: begin test_we = 1; stat_clr_we = 1; end
                10: begin high_we = 1; wdata = wdata & $urandom & $urandom; end
                default: ;
            endcase
            step("R11");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule